// File: doc/BRIEF.md
# Programmable AND-Array Logic with Registered Macrocells

This block models a small programmable array logic device in synthesizable logic. A set of array signals (the external inputs plus one feedback line per output macrocell) is offered to every product term in both true and complemented polarity. A configuration image picks, for each product term, which of those literals take part in the AND. The OR side is hard-wired: each output owns a fixed group of product terms and ORs only those.

Each output macrocell holds a rising-edge D flip-flop that captures the OR result. A path select presents either the combinational OR result or the stored value at the output. An enable marks the output as driven or released; the released state is reported on a separate valid flag instead of high impedance. The flip-flop value of each macrocell is fed back into the array, so the device can be programmed as a synchronous state machine.

The configuration image arrives one bit at a time over a valid/ready port. The port accepts bits only while configuration mode is high. Ready simply follows that mode, so a sender that holds valid while ready is low loses nothing and waits. After a load, a synchronous reset clears the macrocell flip-flops and leaves the image intact.

Top module: `pal_array`

## Requirements
- R1: A configuration bit is accepted on a rising edge when cfg_valid and cfg_ready are both high, and cfg_ready equals cfg_mode. Each accepted bit enters at the top of the image and shifts the rest down, so after CFG_BITS accepts the first bit sent sits at index 0. Array signal s is one of two kinds: index s below N_IN is input s, and index N_IN+o is the feedback of output o. Term k of output o is global term t=o*N_PT+k. Image bit t*2*N_SIG+2*s connects signal s true, and the bit after it connects signal s complemented. Bit FUSE_BITS+o is the path select of output o, and bit FUSE_BITS+N_OUT+o is its enable. With the defaults, N_SIG=12, FUSE_BITS=384 and CFG_BITS=392.
- R2: While cfg_mode is low, cfg_ready is low and cfg_valid/cfg_bit have no effect on the stored image or on any output.
- R3: A product term is the AND of every literal connected to it.
- R4: Output o ORs only its own terms o*N_PT to o*N_PT+N_PT-1. No term is shared with another output.
- R5: A product term with no literal connected evaluates to 0.
- R6: A product term with both polarities of the same signal connected evaluates to 0.
- R7: Each macrocell flip-flop loads, on every rising edge outside reset, the OR result present just before that edge.
- R8: A path select of 1 presents the flip-flop value at out_val. A select of 0 presents the combinational OR result in the same cycle.
- R9: An enable of 1 sets out_oe high. An enable of 0 sets out_oe low and holds out_val at 0.
- R10: Each macrocell's flip-flop value drives its feedback signal in the array. This lets the array implement counters and other state machines.
- R11: A synchronous active-high reset clears every macrocell flip-flop to 0 and leaves the configuration image unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of macrocell flip-flops |
| cfg_mode | input | 1 | Enables configuration loading |
| cfg_valid | input | 1 | Configuration bit present |
| cfg_ready | output | 1 | Configuration bit can be accepted |
| cfg_bit | input | 1 | Serial configuration data |
| in_sig | input | N_IN | External array inputs |
| out_val | output | N_OUT | Macrocell outputs (0 when released) |
| out_oe | output | N_OUT | Output driven flag per macrocell |

## Verification
The assertions check four things on every cycle: that the image holds still when no bit is accepted, that empty and self-contradicting product terms stay at 0, that each flip-flop loads the previous cycle's OR result, and that a registered, enabled output matches the feedback line the array sees. Only the bench's scenarios can show end-to-end behaviour. These cover a programmed 2-bit counter with count enable running through the feedback path, a three-term combinational function over many input patterns, the same function moved to the registered path, released outputs, loads ignored outside configuration mode, and a reset that keeps the image.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {
    PATH_COMB = 1'b0,
    PATH_REG  = 1'b1
  } path_e;

  // position of a literal inside one product term's column slice
  function automatic int col_of(input int sig, input bit neg);
    return 2 * sig + (neg ? 1 : 0);
  endfunction
endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store #(
  parameter int CFG_BITS = 392
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_mode,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic                cfg_bit,
  output logic [CFG_BITS-1:0] cfg_q
);
  logic take;

  assign cfg_ready = cfg_mode;
  assign take      = cfg_valid & cfg_ready;

  always_ff @(posedge clk) begin
    if (take) cfg_q <= {cfg_bit, cfg_q[CFG_BITS-1:1]};
  end

  // R2: image frozen whenever no bit is accepted
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_valid && cfg_mode) |=> $stable(cfg_q));
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int N_SIG   = 12,
  parameter int N_TERMS = 16,
  localparam int COLS   = 2 * N_SIG
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SIG-1:0]         sig,
  input  logic [N_TERMS*COLS-1:0]  fuse,
  output logic [N_TERMS-1:0]       pt
);
  logic [COLS-1:0] lit;

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[pal_pkg::col_of(s, 1'b0)] = sig[s];
    assign lit[pal_pkg::col_of(s, 1'b1)] = ~sig[s];
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [COLS-1:0] conn;
    assign conn  = fuse[t*COLS +: COLS];
    // unused term forced low; otherwise every connected literal must be 1
    assign pt[t] = (|conn) & (&(~conn | lit));

    // R5: empty term stays low
    assert_empty_term_R5: assert property (@(posedge clk) disable iff (rst)
      (conn == '0) |-> !pt[t]);

    for (genvar s = 0; s < N_SIG; s++) begin : g_chk
      // R6: both polarities of one signal kill the term
      assert_contra_term_R6: assert property (@(posedge clk) disable iff (rst)
        (conn[2*s] && conn[2*s+1]) |-> !pt[t]);
    end
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int N_PT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_PT-1:0] pt_grp,
  input  pal_pkg::path_e  path_sel,
  input  logic            enable,
  output logic            q_fb,
  output logic            out_val,
  output logic            out_oe
);
  logic or_res;
  logic q;
  logic path_val;

  assign or_res = |pt_grp;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= or_res;
  end

  always_comb begin
    case (path_sel)
      pal_pkg::PATH_REG: path_val = q;
      default:           path_val = or_res;
    endcase
  end

  assign out_val = enable & path_val;
  assign out_oe  = enable;
  assign q_fb    = q;

  // R7: flip-flop holds the OR result of the previous cycle
  assert_reg_capture_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q == $past(or_res)));
endmodule

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int N_PT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  in_sig,
  output logic [N_OUT-1:0] out_val,
  output logic [N_OUT-1:0] out_oe
);
  localparam int N_SIG     = N_IN + N_OUT;
  localparam int COLS      = 2 * N_SIG;
  localparam int N_TERMS   = N_OUT * N_PT;
  localparam int FUSE_BITS = N_TERMS * COLS;
  localparam int CFG_BITS  = FUSE_BITS + 2 * N_OUT;

  logic [CFG_BITS-1:0] cfg_q;
  logic [N_SIG-1:0]    sig;
  logic [N_TERMS-1:0]  pt;
  logic [N_OUT-1:0]    q_fb;

  pal_cfg_store #(.CFG_BITS(CFG_BITS)) u_cfg (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_bit(cfg_bit), .cfg_q(cfg_q)
  );

  assign sig = {q_fb, in_sig};

  pal_and_plane #(.N_SIG(N_SIG), .N_TERMS(N_TERMS)) u_and (
    .clk(clk), .rst(rst), .sig(sig), .fuse(cfg_q[FUSE_BITS-1:0]), .pt(pt)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_mc
    pal_pkg::path_e sel;
    assign sel = pal_pkg::path_e'(cfg_q[FUSE_BITS + o]);

    pal_macrocell #(.N_PT(N_PT)) u_mc (
      .clk(clk), .rst(rst),
      .pt_grp(pt[o*N_PT +: N_PT]),
      .path_sel(sel),
      .enable(cfg_q[FUSE_BITS + N_OUT + o]),
      .q_fb(q_fb[o]),
      .out_val(out_val[o]),
      .out_oe(out_oe[o])
    );

    // R10: the array sees the same value a registered, driven output shows
    assert_feedback_R10: assert property (@(posedge clk) disable iff (rst)
      (sel == pal_pkg::PATH_REG && out_oe[o]) |-> (sig[N_IN + o] == out_val[o]));
  end
endmodule

// File: tb/pal_array_tb.sv
module pal_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 8, N_OUT = 4, N_PT = 4;
  localparam int N_SIG = N_IN + N_OUT;
  localparam int COLS = 2 * N_SIG;
  localparam int FUSE_BITS = N_OUT * N_PT * COLS;
  localparam int CFG_BITS = FUSE_BITS + 2 * N_OUT;

  logic clk = 0, rst = 1, cfg_mode = 0, cfg_valid = 0, cfg_bit = 0;
  logic cfg_ready;
  logic [N_IN-1:0] in_sig = '0;
  logic [N_OUT-1:0] out_val, out_oe;
  logic [CFG_BITS-1:0] img;
  int errors = 0, checks = 0;
  int cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT)) u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_bit(cfg_bit), .in_sig(in_sig),
    .out_val(out_val), .out_oe(out_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit f_comb(input logic [N_IN-1:0] x);
    return (x[1] & x[2]) | (~x[3] & x[4] & ~x[5]) | (x[6] & ~x[7]);
  endfunction

  task automatic lit(input int o, input int k, input int s, input bit neg);
    img[(o*N_PT + k)*COLS + 2*s + (neg ? 1 : 0)] = 1'b1;
  endtask

  task automatic mc(input int o, input bit reg_path, input bit en);
    img[FUSE_BITS + o] = reg_path;
    img[FUSE_BITS + N_OUT + o] = en;
  endtask

  // outputs 0/1: 2-bit counter, count enable on input 0 (feedback signals 8,9)
  task automatic build_counter();
    lit(0,0,8,0); lit(0,0,0,1);
    lit(0,1,8,1); lit(0,1,0,0);
    lit(1,0,9,0); lit(1,0,8,1);
    lit(1,1,9,0); lit(1,1,0,1);
    lit(1,2,9,1); lit(1,2,8,0); lit(1,2,0,0);
    mc(0,1,1); mc(1,1,1);
  endtask

  task automatic build_fn();
    lit(2,0,1,0); lit(2,0,2,0);
    lit(2,1,3,1); lit(2,1,4,0); lit(2,1,5,1);
    lit(2,2,6,0); lit(2,2,7,1);
  endtask

  task automatic load_img();
    @(negedge clk);
    cfg_mode = 1;
    for (int i = 0; i < CFG_BITS; i++) begin
      cfg_valid = 1; cfg_bit = img[i];
      if (i == 0) begin #1; check("R1 ready in cfg mode", cfg_ready, 1); end
      @(negedge clk);
    end
    cfg_valid = 0; cfg_mode = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; cnt = 0;
    check("R11 counter cleared", out_val[1:0], 0);
  endtask

  task automatic test_reset_state();
    img = '0; build_counter(); build_fn(); lit(3,0,1,0); mc(2,0,1); mc(3,0,0);
    load_img();
    @(negedge clk); rst = 1; @(negedge clk);
    check("R11 reset state", out_val[1:0], 0);
    check("R9 oe pattern", out_oe, 4'b0111);
    check("R1 ready low outside cfg", cfg_ready, 0);
    rst = 0;
  endtask

  task automatic test_count_comb();
    for (int i = 0; i < 40; i++) begin
      logic [N_IN-1:0] x;
      x = N_IN'(i * 53 + 7) ^ N_IN'(i << 3);
      in_sig = x; #1;
      check("R3 R4 comb function", out_val[2], f_comb(x));
      check("R9 released output", {out_oe[3], out_val[3]}, 0);
      @(posedge clk); if (x[0]) cnt = (cnt + 1) % 4;
      @(negedge clk);
      check("R10 counter", out_val[1:0], cnt);
    end
  endtask

  task automatic test_ignore();
    in_sig = '0;
    for (int i = 0; i < 50; i++) begin
      cfg_valid = 1; cfg_bit = i[0];
      #1; check("R2 ready low", cfg_ready, 0);
      @(negedge clk);
    end
    cfg_valid = 0;
    check("R2 counter untouched", out_val[1:0], cnt);
    for (int i = 0; i < 8; i++) begin
      logic [N_IN-1:0] x;
      x = N_IN'(i * 91 + 2) & 8'hFE;
      in_sig = x; #1;
      check("R2 function kept", out_val[2], f_comb(x));
      check("R2 out3 still released", out_oe[3], 0);
      @(negedge clk);
    end
  endtask

  task automatic test_mid_reset();
    in_sig = 8'h01;
    repeat (3) begin @(posedge clk); cnt = (cnt + 1) % 4; end
    @(negedge clk); check("R10 count before reset", out_val[1:0], cnt);
    do_reset();
    in_sig = 8'h12; #1;
    check("R11 image kept", out_val[2], f_comb(8'h12));
  endtask

  task automatic test_reg_and_dead_terms();
    img = '0; build_counter(); build_fn(); mc(2,1,1);
    lit(3,0,1,0); lit(3,0,1,1);   // contradictory term
    lit(3,2,3,0);                 // term 1 left empty
    mc(3,0,1);
    in_sig = '0;
    load_img();
    do_reset();
    check("R8 registered out after reset", out_val[2], 0);
    for (int i = 0; i < 30; i++) begin
      logic [N_IN-1:0] x;
      x = N_IN'(i * 29 + 5) ^ N_IN'(i << 5);
      in_sig = x; #1;
      check("R5 R6 R4 out3 equals input3", out_val[3], x[3]);
      @(posedge clk); if (x[0]) cnt = (cnt + 1) % 4;
      @(negedge clk);
      check("R7 R8 registered function", out_val[2], f_comb(x));
      check("R10 counter B", out_val[1:0], cnt);
    end
  endtask

  initial begin
    fork
      begin
        test_reset_state();
        test_count_comb();
        test_ignore();
        test_mid_reset();
        test_reg_and_dead_terms();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule